// File: doc/BRIEF.md
# Gate-Synchronous Serial Counter Frame Transmitter

This block sends a snapshot of per-pixel counter values once per gate period. It watches a slow gate signal that runs beside the readout clock. On each rising edge of the gate it takes a copy of all counter inputs and sends one frame on every serial line at once, one bit per readout clock. A flag stays high for as long as the frame lasts, so a receiver knows when to sample the lines.

Each line carries a fixed number of channel counters. Its frame has three parts in this order: a start bit of 1, then the counters from channel 0 upward with the most significant bit of each first, then one parity bit. The parity bit is 1 when the data bits hold an even number of ones. With the default settings there are eight counting lines and a ninth line for a charge channel. Each line carries eight 8-bit counters, so a frame is 66 clocks long and fits easily inside a 100-clock gate period.

Top module: `gtu_frame_tx`

## Requirements
- R1: A rising edge on `gate_in` passes through two synchronizer flops and an edge detector. If `gate_in` changes just after clock edge n, `tx_on` goes high after edge n+3 and stays low before that.
- R2: Once `tx_on` goes high it stays high for exactly FRAME_LEN = CH_PER_LINE*CNT_W + 2 clocks (66 with the defaults).
- R3: Frame bit 0 is 1 on every line.
- R4: Frame bits 1 to CH_PER_LINE*CNT_W carry channel 0 first and the last channel at the end, each with its MSB first. Channel c of line L is taken from `counters_in[(L*CH_PER_LINE + c)*CNT_W +: CNT_W]`.
- R5: The last frame bit is the parity bit. It is 1 when the line's data bits hold an even number of ones and 0 when they hold an odd number; the start bit is not counted.
- R6: While `tx_on` is low, every bit of `ser_out` is 0.
- R7: A rising gate edge that is detected while a frame is still being sent is dropped. It does not change the running frame, and no frame follows it.
- R8: The counters are copied on the clock edge that starts a frame. Changes to `counters_in` after that edge do not show up in the frame.
- R9: All NUM_LINES lines send in the same clock cycles, each carrying its own counters.
- R10: While `rst_n` is low, `tx_on` and `ser_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Gate-period signal, not synchronized to `clk` |
| counters_in | input | NUM_LINES*CH_PER_LINE*CNT_W | Counter values for all lines, packed line by line and then channel by channel |
| ser_out | output | NUM_LINES | Serial data lines, one bit per line |
| tx_on | output | 1 | High for the duration of a frame |

## Verification
The bench uses the default sizes: nine lines of eight 8-bit channels each. This makes the full 66-bit frame and the separate ninth line part of every run. Because the channel width is 8, each channel's MSB-first ordering and the count of ones behind the parity bit can be checked one bit at a time. The 66-clock frame is short enough for the bench to raise a second gate edge in the middle of a frame and then check that no frame follows it.

// File: rtl/gtu_tx_pkg.sv
package gtu_tx_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SEND = 1'b1
  } seq_state_e;

  // start bit + data + parity
  function automatic int frame_bits(input int ch_per_line, input int cnt_w);
    return ch_per_line * cnt_w + 2;
  endfunction

  // width of an index that counts 0 .. n-1
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/gtu_gate_edge.sv
module gtu_gate_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic rise_evt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= gate_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_evt = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/gtu_frame_seq.sv
module gtu_frame_seq
  import gtu_tx_pkg::*;
#(
  parameter int FRAME_LEN = 66,
  localparam int IDX_W    = idx_width(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  output logic             capture,
  output logic             active,
  output logic [IDX_W-1:0] bit_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_bit;

  assign last_bit = (idx_q == LAST_IDX);
  assign capture  = rise_evt && (state_q == SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          idx_q <= '0;
          if (capture) state_q <= SEQ_SEND;
        end
        SEQ_SEND: begin
          if (last_bit) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign active  = (state_q == SEQ_SEND);
  assign bit_idx = idx_q;

endmodule

// File: rtl/gtu_lane_ser.sv
module gtu_lane_ser
  import gtu_tx_pkg::*;
#(
  parameter int CH_PER_LINE = 8,
  parameter int CNT_W       = 8,
  localparam int DATA_W     = CH_PER_LINE * CNT_W,
  localparam int FRAME_LEN  = frame_bits(CH_PER_LINE, CNT_W),
  localparam int IDX_W      = idx_width(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              active,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] cnt_in,
  output logic              ser
);

  logic [DATA_W-1:0] shadow_q;
  logic              par_q;

  // 1 for an even count of ones
  function automatic logic even_ones(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  // bit sent at frame position idx
  function automatic logic pick_bit(input logic [DATA_W-1:0] d,
                                    input logic              par,
                                    input logic [IDX_W-1:0]  idx);
    int k;
    int ch;
    int b;
    if (idx == '0) return 1'b1;
    if (idx == IDX_W'(FRAME_LEN - 1)) return par;
    k  = int'(idx) - 1;
    ch = k / CNT_W;
    b  = CNT_W - 1 - (k % CNT_W);
    return d[ch*CNT_W + b];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      par_q    <= 1'b0;
    end else if (capture) begin
      shadow_q <= cnt_in;
      par_q    <= even_ones(cnt_in);
    end
  end

  assign ser = active ? pick_bit(shadow_q, par_q, bit_idx) : 1'b0;

endmodule

// File: rtl/gtu_frame_tx.sv
module gtu_frame_tx
  import gtu_tx_pkg::*;
#(
  parameter int NUM_LINES   = 9,
  parameter int CH_PER_LINE = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 gate_in,
  input  logic [NUM_LINES*CH_PER_LINE*CNT_W-1:0] counters_in,
  output logic [NUM_LINES-1:0]                 ser_out,
  output logic                                 tx_on
);

  localparam int DATA_W    = CH_PER_LINE * CNT_W;
  localparam int FRAME_LEN = frame_bits(CH_PER_LINE, CNT_W);
  localparam int IDX_W     = idx_width(FRAME_LEN);

  logic             rise_evt;
  logic             capture;
  logic             active;
  logic [IDX_W-1:0] bit_idx;

  gtu_gate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_in  (gate_in),
    .rise_evt (rise_evt)
  );

  gtu_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .capture  (capture),
    .active   (active),
    .bit_idx  (bit_idx)
  );

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_lane
      gtu_lane_ser #(.CH_PER_LINE(CH_PER_LINE), .CNT_W(CNT_W)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .active  (active),
        .bit_idx (bit_idx),
        .cnt_in  (counters_in[l*DATA_W +: DATA_W]),
        .ser     (ser_out[l])
      );
    end
  endgenerate

  assign tx_on = active;

endmodule

// File: rtl/gtu_frame_tx_chk.sv
module gtu_frame_tx_chk #(
  parameter int NUM_LINES = 9,
  parameter int FRAME_LEN = 66,
  parameter int IDX_W     = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_on,
  input logic [NUM_LINES-1:0] ser_out,
  input logic                 rise_evt,
  input logic [IDX_W-1:0]     bit_idx
);

  localparam int RUN_W = $clog2(FRAME_LEN + 1) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (tx_on) run_len <= run_len + RUN_W'(1);
    else            run_len <= '0;
  end

  // R1
  frame_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> $past(rise_evt));

  // R2
  frame_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_on) |-> (run_len == RUN_W'(FRAME_LEN)));

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> (ser_out == {NUM_LINES{1'b1}}));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> (ser_out == '0));

  // R7
  busy_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && rise_evt && (bit_idx != IDX_W'(FRAME_LEN - 1)))
      |=> (tx_on && (bit_idx == $past(bit_idx) + IDX_W'(1))));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!tx_on && (ser_out == '0)));

endmodule

bind gtu_frame_tx gtu_frame_tx_chk #(
  .NUM_LINES (NUM_LINES),
  .FRAME_LEN (FRAME_LEN),
  .IDX_W     (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_on    (tx_on),
  .ser_out  (ser_out),
  .rise_evt (rise_evt),
  .bit_idx  (bit_idx)
);

// File: tb/gtu_frame_tx_bench.sv
module gtu_frame_tx_bench;

  localparam int NL   = 9;
  localparam int CH   = 8;
  localparam int W    = 8;
  localparam int DW   = CH * W;
  localparam int TOT  = NL * DW;
  localparam int FLEN = DW + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           gate_in = 1'b0;
  logic [TOT-1:0] counters_in = '0;
  logic [NL-1:0]  ser_out;
  logic           tx_on;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NL-1:0] exp_q[$];

  always #2 clk = ~clk;

  gtu_frame_tx #(.NUM_LINES(NL), .CH_PER_LINE(CH), .CNT_W(W), .SYNC_STAGES(2)) u_gtu_frame_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_in     (gate_in),
    .counters_in (counters_in),
    .ser_out     (ser_out),
    .tx_on       (tx_on)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected bit of a line at frame position p
  function automatic logic exp_bit(input logic [TOT-1:0] c, input int line, input int p);
    int ones;
    if (p == 0) return 1'b1;
    if (p == FLEN - 1) begin
      ones = 0;
      for (int i = 0; i < DW; i++) ones += int'(c[line*DW + i]);
      return (ones % 2 == 0);
    end
    return c[(line*CH + (p-1)/W)*W + (W - 1 - (p-1)%W)];
  endfunction

  task automatic push_frame(input logic [TOT-1:0] c);
    for (int p = 0; p < FLEN; p++) begin
      logic [NL-1:0] v;
      for (int l = 0; l < NL; l++) v[l] = exp_bit(c, l, p);
      exp_q.push_back(v);
    end
  endtask

  task automatic run_frame(input logic [TOT-1:0] c, input bit mid_edge);
    int guard;
    counters_in = c;
    push_frame(c);
    gate_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check(tx_on == 1'b0, "R1 early", 64'(tx_on), 64'd0);
    @(negedge clk);
    check(tx_on == 1'b1, "R1 start", 64'(tx_on), 64'd1);
    counters_in = ~c; // R8: change after capture
    if (mid_edge) begin
      repeat (5) @(negedge clk);
      gate_in = 1'b0;
      repeat (3) @(negedge clk);
      gate_in = 1'b1; // R7: edge during frame
    end
    guard = 0;
    while (tx_on && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    gate_in = 1'b0;
    repeat (12) begin
      @(negedge clk);
      check(tx_on == 1'b0, "R7 no extra frame", 64'(tx_on), 64'd0);
    end
  endtask

  // monitor / scoreboard
  initial begin
    int pos;
    int run;
    pos = 0;
    run = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        check(tx_on == 1'b0 && ser_out == '0, "R10", 64'({tx_on, ser_out}), 64'd0);
      end else if (tx_on) begin
        run++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected frame bit", 64'(ser_out), 64'd0);
        end else begin
          logic [NL-1:0] e;
          e = exp_q.pop_front();
          if (pos == 0)             check(ser_out == e, "R3", 64'(ser_out), 64'(e));
          else if (pos == FLEN - 1) check(ser_out == e, "R5", 64'(ser_out), 64'(e));
          else                      check(ser_out == e, "R4 R8 R9", 64'(ser_out), 64'(e));
        end
        pos++;
      end else begin
        if (run != 0) check(run == FLEN, "R2", 64'(run), 64'(FLEN));
        run = 0;
        pos = 0;
        check(ser_out == '0, "R6", 64'(ser_out), 64'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] pat;
    logic [31:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_frame('0, 1'b0);                 // all zero: parity 1
    run_frame({TOT{1'b1}}, 1'b0);        // all ones: 64 ones, parity 1

    pat = '0;                            // one bit per line: odd count
    for (int l = 0; l < NL; l++) pat[l*DW + (l*7) % DW] = 1'b1;
    run_frame(pat, 1'b0);

    pat = '0;                            // channel index in each counter
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < CH; c++)
        pat[(l*CH + c)*W +: W] = W'(8'h80 >> c) | W'(l);
    run_frame(pat, 1'b1);

    lf = 32'hACE1_2345;                  // pseudo-random
    for (int i = 0; i < TOT; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      pat[i] = lf[0];
    end
    run_frame(pat, 1'b1);

    check(exp_q.size() == 0, "R2 all frames sent", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule